// File: doc/BRIEF.md
# Serial Port Receive Buffer with Switchable Depth

This block holds received characters for a 16550-style serial port. Characters arrive from the serial receive path. When loopback is active they come from writes to the transmit data register instead, and anything on the serial path is read and thrown away. Software takes characters out through the data register read port. It sees their presence and any lost character in the line status byte.

The buffer has two run-time depths. In legacy mode it holds a single character, like a plain holding register. In FIFO mode it holds sixteen. Writes to the FIFO control register select the mode and can clear the buffer. The control register keeps only the enable, DMA-mode and trigger-level bits. Reads of the data register and of the line status register are strobes: the read value is present during the strobe cycle, and the side effect (pop, or clearing the overrun flag) takes place at the end of that cycle.

Top module: `serial_rxq`

## Requirements
- R1: After reset the buffer is empty, the stored control value is 0x00, the depth is one entry, the overrun flag is clear and `rx_ready` is high.
- R2: A control write whose bit 0 (enable) differs from the stored enable flushes the buffer. From the next cycle the depth is 16 if the new enable is 1, otherwise 1.
- R3: A control write with bit 0 clear stores 0x00 and ignores every other bit. For example, 0x02 written while already in legacy mode leaves a buffered byte in place.
- R4: A control write with bit 0 and bit 1 (receiver clear) both set flushes the buffer and keeps the depth at 16.
- R5: A control write with bit 0 set stores only bits 0, 3 (DMA mode), 6 and 7 (trigger level); the other bits read back as 0 (mask 0xC9).
- R6: While `loopback` is high, `lb_wr` pushes `lb_wdata`. If the buffer is full, the byte is dropped and the overrun flag is set. Serial input is discarded and `rx_ready` stays high. While `loopback` is low, `lb_wr` leaves the buffer alone.
- R7: `lsr_rdata` always has bit 5 (holding register empty) and bit 6 (transmitter empty) set. Bit 0 (data ready) is 1 exactly when the buffer holds at least one byte, bit 1 is the overrun flag, and all other bits are 0.
- R8: An `lsr_rd` strobe clears the overrun flag at the end of its cycle, unless a new overrun occurs in that same cycle.
- R9: A data read while the buffer is empty returns 0xFF and changes nothing. The next byte written is the next byte read.
- R10: Outside loopback, `rx_ready` is low exactly when the occupancy equals the current depth. A byte offered while it is low is not stored.
- R11: Bytes leave in arrival order. The pointers wrap at the current depth, so at depth 16 the order survives any mix of pushes and pops across the wrap.
- R12: When a control write flushes the buffer, a push or pop requested in the same cycle is discarded and the buffer is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the FIFO control register |
| ctl_wdata | input | 8 | Value written to the FIFO control register |
| ctl_q | output | 8 | Stored control value |
| loopback | input | 1 | Loopback mode active |
| lb_wr | input | 1 | Transmit data register write strobe |
| lb_wdata | input | 8 | Transmit data register write value |
| rx_valid | input | 1 | Serial receive path offers a byte |
| rx_data | input | 8 | Byte offered by the serial receive path |
| rx_ready | output | 1 | Buffer can take a byte from the serial path |
| dat_rd | input | 1 | Data register read strobe (pops at end of cycle) |
| dat_rdata | output | 8 | Oldest byte, or 0xFF when empty |
| lsr_rd | input | 1 | Line status read strobe (clears overrun at end of cycle) |
| lsr_rdata | output | 8 | Line status byte |
| fill_level | output | 5 | Number of bytes held |

## Verification
The assertions check the invariants on every cycle. Occupancy never exceeds the current depth. `rx_ready` drops at full outside loopback and stays high in loopback. The fixed transmitter bits and the data-ready bit match the occupancy. An empty read shows 0xFF. The stored control value never carries bits outside the kept mask. They also check the one-cycle consequences of control writes (flush on a mode change or receiver clear, zero on disable) and of overrun set and clear. Only the bench scenarios can show that bytes come out in the order they went in across the pointer wrap. The bench also shows which byte survives an overrun, that a non-flushing write leaves contents intact, and that the depth after a flush really is 1 or 16.

// File: rtl/serial_rxq_pkg.sv
package serial_rxq_pkg;

    localparam int BYTE_W       = 8;
    localparam int MAX_DEPTH    = 16;
    localparam int LEGACY_DEPTH = 1;

    // Control register bit positions (software decodes these)
    localparam int CTL_EN    = 0;
    localparam int CTL_RXCLR = 1;
    localparam int CTL_DMA   = 3;
    localparam int CTL_TRG0  = 6;
    localparam int CTL_TRG1  = 7;

    localparam logic [BYTE_W-1:0] CTL_KEEP_MASK =
        BYTE_W'((1 << CTL_EN) | (1 << CTL_DMA) | (1 << CTL_TRG0) | (1 << CTL_TRG1));

    // Line status bit positions
    localparam int LSR_DR   = 0;
    localparam int LSR_OVR  = 1;
    localparam int LSR_THRE = 5;
    localparam int LSR_TEMT = 6;

    localparam logic [BYTE_W-1:0] EMPTY_READ = 8'hFF;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_FIFO   = 1'b1
    } rxq_mode_e;

    typedef struct packed {
        logic              push;
        logic              pop;
        logic              flush;
        logic [BYTE_W-1:0] data;
    } rxq_op_t;

    function automatic logic [BYTE_W-1:0] make_lsr(input logic ready, input logic ovr);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[LSR_DR]   = ready;
        v[LSR_OVR]  = ovr;
        v[LSR_THRE] = 1'b1;
        v[LSR_TEMT] = 1'b1;
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] filter_ctl(input logic [BYTE_W-1:0] wv);
        return wv[CTL_EN] ? (wv & CTL_KEEP_MASK) : '0;
    endfunction

endpackage

// File: rtl/serial_rxq_ctl.sv
module serial_rxq_ctl
    import serial_rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctl_q,
    output rxq_mode_e         mode,
    output logic              flush
);

    logic [BYTE_W-1:0] ctl_r;
    logic              en_change;
    logic              rx_clear;

    always_comb begin
        en_change = wdata[CTL_EN] != ctl_r[CTL_EN];
        rx_clear  = wdata[CTL_EN] && wdata[CTL_RXCLR];
        flush     = wr && (en_change || rx_clear);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_r <= '0;
        end else if (wr) begin
            ctl_r <= filter_ctl(wdata);
        end
    end

    assign ctl_q = ctl_r;
    assign mode  = ctl_r[CTL_EN] ? MODE_FIFO : MODE_LEGACY;

endmodule

// File: rtl/serial_rxq_buf.sv
module serial_rxq_buf
    import serial_rxq_pkg::*;
#(
    parameter int DEPTH = MAX_DEPTH,
    parameter int DW    = BYTE_W,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] cap,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    head,
    output logic [LVL_W-1:0] level,
    output logic             full
);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic [LVL_W-1:0] cnt;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                              input logic [LVL_W-1:0] lim);
        logic [LVL_W:0] nxt;
        nxt = (LVL_W+1)'(p) + 1'b1;
        return (nxt >= (LVL_W+1)'(lim)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = cnt >= cap;
        do_push = push && !full && !flush;
        do_pop  = pop && (cnt != '0) && !flush;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) begin
                wptr <= step(wptr, cap);
            end
            if (do_pop) begin
                rptr <= step(rptr, cap);
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rptr];
    assign level = cnt;

endmodule

// File: rtl/serial_rxq_stat.sv
module serial_rxq_stat
    import serial_rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ovr_set,
    input  logic              ovr_clr,
    input  logic              has_data,
    output logic [BYTE_W-1:0] lsr
);

    logic ovr_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_r <= 1'b0;
        end else if (ovr_set) begin
            ovr_r <= 1'b1;
        end else if (ovr_clr) begin
            ovr_r <= 1'b0;
        end
    end

    assign lsr = make_lsr(has_data, ovr_r);

endmodule

// File: rtl/serial_rxq.sv
module serial_rxq
    import serial_rxq_pkg::*;
#(
    parameter int FIFO_DEPTH = MAX_DEPTH,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_q,
    input  logic              loopback,
    input  logic              lb_wr,
    input  logic [7:0]        lb_wdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic              dat_rd,
    output logic [7:0]        dat_rdata,
    input  logic              lsr_rd,
    output logic [7:0]        lsr_rdata,
    output logic [LVL_W-1:0]  fill_level
);

    rxq_mode_e          mode;
    rxq_op_t            op;
    logic               flush;
    logic [LVL_W-1:0]   cap;
    logic [BYTE_W-1:0]  head;
    logic [LVL_W-1:0]   level;
    logic               full;

    serial_rxq_ctl u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl_q (ctl_q),
        .mode  (mode),
        .flush (flush)
    );

    assign cap = (mode == MODE_FIFO) ? LVL_W'(FIFO_DEPTH) : LVL_W'(LEGACY_DEPTH);

    always_comb begin
        op.flush = flush;
        op.pop   = dat_rd;
        if (loopback) begin
            op.push = lb_wr;
            op.data = lb_wdata;
        end else begin
            op.push = rx_valid;
            op.data = rx_data;
        end
    end

    serial_rxq_buf #(
        .DEPTH (FIFO_DEPTH),
        .DW    (BYTE_W)
    ) u_buf (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .push  (op.push),
        .pop   (op.pop),
        .flush (op.flush),
        .wdata (op.data),
        .head  (head),
        .level (level),
        .full  (full)
    );

    serial_rxq_stat u_stat (
        .clk      (clk),
        .rst      (rst),
        .ovr_set  (loopback && lb_wr && full),
        .ovr_clr  (lsr_rd),
        .has_data (level != '0),
        .lsr      (lsr_rdata)
    );

    assign rx_ready   = loopback || !full;
    assign dat_rdata  = (level != '0) ? head : EMPTY_READ;
    assign fill_level = level;

endmodule

// File: rtl/serial_rxq_chk.sv
module serial_rxq_chk #(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_wr,
    input logic [7:0]       ctl_wdata,
    input logic [7:0]       ctl_q,
    input logic             loopback,
    input logic             lb_wr,
    input logic             rx_ready,
    input logic [7:0]       dat_rdata,
    input logic             lsr_rd,
    input logic [7:0]       lsr_rdata,
    input logic [LVL_W-1:0] fill_level
);

    logic [LVL_W-1:0] cap;
    logic             lb_overrun;

    assign cap        = ctl_q[0] ? LVL_W'(FIFO_DEPTH) : LVL_W'(1);
    assign lb_overrun = loopback && lb_wr && (fill_level == cap);

    AST_LEVEL_IN_CAP: assert property (@(posedge clk) disable iff (rst)
        fill_level <= cap); // R2
    AST_READY_FULL: assert property (@(posedge clk) disable iff (rst)
        !loopback |-> (rx_ready == (fill_level != cap))); // R10
    AST_LB_READY: assert property (@(posedge clk) disable iff (rst)
        loopback |-> rx_ready); // R6
    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && (ctl_wdata[0] != ctl_q[0]) |=> fill_level == '0); // R12
    AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && !ctl_wdata[0] |=> ctl_q == 8'h00); // R3
    AST_RXCLR_FLUSH: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && ctl_wdata[0] && ctl_wdata[1] |=> (fill_level == '0) && ctl_q[0]); // R4
    AST_CTL_MASK: assert property (@(posedge clk) disable iff (rst)
        (ctl_q & 8'h36) == 8'h00); // R5
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        lb_overrun |=> lsr_rdata[1]); // R6
    AST_TX_BITS: assert property (@(posedge clk) disable iff (rst)
        lsr_rdata[6:5] == 2'b11 && (lsr_rdata & 8'h9C) == 8'h00); // R7
    AST_DR_FLAG: assert property (@(posedge clk) disable iff (rst)
        lsr_rdata[0] == (fill_level != '0)); // R7
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        lsr_rd && !lb_overrun |=> !lsr_rdata[1]); // R8
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        fill_level == '0 |-> dat_rdata == 8'hFF); // R9

endmodule

bind serial_rxq serial_rxq_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ctl_q      (ctl_q),
    .loopback   (loopback),
    .lb_wr      (lb_wr),
    .rx_ready   (rx_ready),
    .dat_rdata  (dat_rdata),
    .lsr_rd     (lsr_rd),
    .lsr_rdata  (lsr_rdata),
    .fill_level (fill_level)
);

// File: tb/serial_rxq_bench.sv
`timescale 1ns/1ps
module serial_rxq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_q;
    logic       loopback = 1'b0;
    logic       lb_wr = 1'b0;
    logic [7:0] lb_wdata = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready;
    logic       dat_rd = 1'b0;
    logic [7:0] dat_rdata;
    logic       lsr_rd = 1'b0;
    logic [7:0] lsr_rdata;
    logic [4:0] fill_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    serial_rxq u_serial_rxq (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .ctl_q      (ctl_q),
        .loopback   (loopback),
        .lb_wr      (lb_wr),
        .lb_wdata   (lb_wdata),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .dat_rd     (dat_rd),
        .dat_rdata  (dat_rdata),
        .lsr_rd     (lsr_rd),
        .lsr_rdata  (lsr_rdata),
        .fill_level (fill_level)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1;
        ctl_wr = 0; lb_wr = 0; rx_valid = 0; dat_rd = 0; lsr_rd = 0;
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v;
        finish_cycle();
    endtask

    task automatic rx_send(input logic [7:0] d);
        @(negedge clk); rx_valid = 1; rx_data = d;
        finish_cycle();
    endtask

    task automatic lb_send(input logic [7:0] d);
        @(negedge clk); lb_wr = 1; lb_wdata = d;
        finish_cycle();
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk); dat_rd = 1; #2 d = dat_rdata;
        finish_cycle();
    endtask

    task automatic lsr_read(output logic [7:0] v);
        @(negedge clk); lsr_rd = 1; #2 v = lsr_rdata;
        finish_cycle();
    endtask

    task automatic t_reset();
        check("R1", "level", fill_level, 0);
        check("R1", "ctl_q", ctl_q, 8'h00);
        check("R1", "rx_ready", rx_ready, 1);
        check("R7", "lsr idle", lsr_rdata, 8'h60);
        rx_send(8'h5A);
        check("R1", "depth one, ready low", rx_ready, 0);
    endtask

    task automatic t_legacy();
        logic [7:0] d;
        check("R7", "lsr data ready", lsr_rdata, 8'h61);
        rx_send(8'h33);
        check("R10", "level after refused byte", fill_level, 1);
        pop(d);
        check("R10", "kept byte", d, 8'h5A);
        pop(d);
        check("R9", "empty read value", d, 8'hFF);
        check("R9", "empty read level", fill_level, 0);
        rx_send(8'h11);
        pop(d);
        check("R9", "byte after empty read", d, 8'h11);
    endtask

    task automatic t_ctl_fields();
        logic [7:0] d;
        rx_send(8'h42);
        ctl_write(8'h02);
        check("R3", "disabled write stores zero", ctl_q, 8'h00);
        check("R3", "rx clear ignored while disabled", fill_level, 1);
        ctl_write(8'hFF);
        check("R5", "kept bits", ctl_q, 8'hC9);
        check("R2", "enable flushes", fill_level, 0);
        ctl_write(8'h0E);
        check("R3", "enable clear zeroes", ctl_q, 8'h00);
        pop(d);
        check("R9", "empty after disable", d, 8'hFF);
    endtask

    task automatic t_fifo_order();
        logic [7:0] d;
        ctl_write(8'h01);
        check("R2", "fifo mode after enable", ctl_q, 8'h01);
        for (int i = 0; i < 16; i++) rx_send(8'h10 + 8'(i));
        check("R2", "depth sixteen", fill_level, 16);
        check("R10", "ready low at sixteen", rx_ready, 0);
        for (int i = 0; i < 5; i++) begin
            pop(d);
            check("R11", "order before wrap", d, 8'h10 + i);
        end
        for (int i = 0; i < 5; i++) rx_send(8'h20 + 8'(i));
        check("R11", "level after wrap refill", fill_level, 16);
        for (int i = 0; i < 16; i++) begin
            pop(d);
            check("R11", "order across wrap", d, (i < 11) ? (8'h15 + i) : (8'h20 + i - 11));
        end
    endtask

    task automatic t_rx_clear();
        for (int i = 0; i < 3; i++) rx_send(8'hA0 + 8'(i));
        ctl_write(8'h03);
        check("R4", "receiver clear flushes", fill_level, 0);
        check("R4", "still enabled", ctl_q, 8'h01);
        for (int i = 0; i < 16; i++) rx_send(8'h30 + 8'(i));
        check("R4", "depth stays sixteen", fill_level, 16);
    endtask

    task automatic t_flush_wins();
        @(negedge clk);
        ctl_wr = 1; ctl_wdata = 8'h00; rx_valid = 1; rx_data = 8'hEE; dat_rd = 1;
        finish_cycle();
        check("R12", "flush over push and pop", fill_level, 0);
        check("R2", "legacy after disable", ctl_q, 8'h00);
        rx_send(8'h01);
        rx_send(8'h02);
        check("R2", "depth one after disable", fill_level, 1);
    endtask

    task automatic t_loopback();
        logic [7:0] d;
        logic [7:0] v;
        pop(d);
        loopback = 1;
        lb_send(8'hA1);
        check("R6", "loopback push", fill_level, 1);
        rx_send(8'h77);
        check("R6", "serial discarded", fill_level, 1);
        check("R6", "ready high in loopback", rx_ready, 1);
        lb_send(8'hB2);
        check("R6", "overrun flagged", lsr_rdata, 8'h63);
        @(negedge clk); lb_wr = 1; lb_wdata = 8'hC3; lsr_rd = 1;
        finish_cycle();
        check("R8", "new overrun beats clear", lsr_rdata, 8'h63);
        lsr_read(v);
        check("R8", "read shows overrun", v, 8'h63);
        check("R8", "cleared after read", lsr_rdata, 8'h61);
        pop(d);
        check("R6", "first byte kept", d, 8'hA1);
        loopback = 0;
        lb_send(8'h99);
        check("R6", "lb write ignored off loopback", fill_level, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_legacy();
        t_ctl_fields();
        t_fifo_order();
        t_rx_clear();
        t_flush_wins();
        t_loopback();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule